// File: doc/BRIEF.md
# Framed Receive Packet FIFO

This block sits between a receive MAC and a host. It takes incoming frames as a byte stream, one byte per cycle, and stores each accepted frame in a byte FIFO as a self-describing record. Each record has a fixed marker word, then a header word, then the payload. Short payloads are zero-filled to the minimum frame size. A generated CRC-32 follows the payload, and zero bytes then fill the record out to the next 4-byte boundary. The header holds the stored length and a success code.

The host reads the FIFO one 32-bit word at a time through a single data port. It can see how many complete records are waiting. The block follows the host's position inside the current record. It knows that the first word is the marker and the second is the header. From the header length it works out where the record ends. It then counts the record as consumed.

A frame is admitted at its first byte, using a length supplied with that byte. The frame is admitted only if reception is enabled and the whole record fits in the free space. Otherwise the frame is discarded. A finished record raises an interrupt flag, which the host clears. A ready output tells the upstream side that any full-size frame would fit.

Top module: `rx_record_fifo`

## Requirements
- R1: A payload of fewer than MIN_LEN bytes is followed by zero bytes up to MIN_LEN. The stored length is max(payload, MIN_LEN).
- R2: A record is written in this order: marker word (parameter MARKER), header word, stored payload, CRC word, then zero bytes up to the next multiple of 4. Its total size is 8 + roundup4(stored length + 4).
- R3: Header bits [15:0] hold the stored length plus 4. Header bits [31:16] hold the parameter OK_CODE.
- R4: The CRC is the reflected CRC-32 (polynomial 0xEDB88320). It starts from 0xFFFFFFFF, runs over the stored payload including the zero fill and excluding the alignment bytes, and is stored complemented.
- R5: A frame is stored only if rx_en is 1 at its first byte and the free space is at least 8 + roundup4(max(in_len, MIN_LEN) + 4). Otherwise none of its bytes reach the FIFO and pend_cnt does not change.
- R6: rdy is 1 exactly when rx_en is 1, no frame is being written, and the free space is at least RDY_MIN bytes.
- R7: Finishing a record raises pend_cnt by one and sets irq. Writing irq_clr=1 clears irq.
- R8: Words are stored and read least significant byte first. Byte k of a word sits in bits [8k+7:8k].
- R9: A read pulse on rd_stb pops the word shown on rd_word. After the marker and the header, roundup4(header length) / 4 body words remain. Popping the last of them lowers pend_cnt by one, and the next word read is the next record's marker.
- R10: A read pulse while pend_cnt is 0 pops nothing. rd_err is 1 in the following cycle only.
- R11: A frame that starts while an earlier record is still being written is discarded whole.
- R12: The stored byte count never exceeds DEPTH, and a pop never takes more than is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled at each frame's first byte |
| in_valid | input | 1 | A frame byte is present |
| in_first | input | 1 | This byte is the first of a frame |
| in_last | input | 1 | This byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_len | input | LEN_W | Frame length in bytes, valid with in_first |
| rdy | output | 1 | A full-size frame would be accepted |
| rd_stb | input | 1 | Host pops one word |
| rd_word | output | 32 | Word at the head of the FIFO |
| rd_err | output | 1 | The previous pop found no pending record |
| pend_cnt | output | $clog2(DEPTH) | Number of complete records waiting |
| irq | output | 1 | Receive interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |

## Verification
The bench builds the block with DEPTH=256 and RDY_MIN=100. At this size two 100-byte frames nearly fill the FIFO. That makes three cases reachable in a few hundred cycles: the ready output falling, a small frame being rejected for lack of space, and both read and write pointers wrapping many times. Every payload length from 1 to 72 is swept. This covers every zero-fill length and all four alignment residues on both sides of MIN_LEN=60. Each word of each record is compared with a layout and CRC that the bench computes arithmetically.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int HDR_BYTES = 8;
   localparam int CRC_BYTES = 4;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      W_IDLE,
      W_DATA,
      W_PAD,
      W_CRC,
      W_ALIGN,
      W_HEAD,
      W_SKIP
   } wr_state_t;

   typedef enum logic [1:0] {
      P_MARK,
      P_HDR,
      P_BODY
   } rd_pos_t;

   function automatic int round_up4(input int v);
      return (v + 3) & ~3;
   endfunction

   function automatic int record_bytes(input int stored_len);
      return HDR_BYTES + round_up4(stored_len + CRC_BYTES);
   endfunction

endpackage

// File: rtl/rxq_crc_step.sv
module rxq_crc_step #(
   parameter int          BITS = 8,
   parameter logic [31:0] POLY = 32'hEDB8_8320
) (
   input  logic [31:0]     crc_in,
   input  logic [BITS-1:0] data_in,
   output logic [31:0]     crc_out
);

   logic [31:0] chain [BITS+1];

   assign chain[0] = crc_in;

   for (genvar b = 0; b < BITS; b++) begin : g_bit
      logic fb;
      assign fb = chain[b][0] ^ data_in[b];
      assign chain[b+1] = (chain[b] >> 1) ^ (fb ? POLY : 32'h0);
   end

   assign crc_out = chain[BITS];

endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
   import rxq_pkg::*;
#(
   parameter int          AW      = 12,
   parameter int          LW      = 16,
   parameter int          MIN_LEN = 60,
   parameter logic [31:0] MARKER  = 32'hA5C3_0F1E,
   parameter logic [15:0] OK_CODE = 16'h0001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic          in_valid,
   input  logic          in_first,
   input  logic          in_last,
   input  logic [7:0]    in_data,
   input  logic [LW-1:0] in_len,
   input  logic [AW:0]   free_bytes,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_byte,
   output logic          commit,
   output logic [AW:0]   commit_bytes,
   output logic          idle
);

   localparam int          PAD_END  = HDR_BYTES + MIN_LEN;
   localparam logic [LW-1:0] OFF_PAD_END = LW'(PAD_END);
   localparam logic [LW-1:0] OFF_FIRST   = LW'(HDR_BYTES);

   wr_state_t     state_q;
   logic [AW-1:0] base_q;
   logic [LW-1:0] off_q;
   logic [31:0]   crc_q;
   logic [2:0]    sub_q;
   logic [15:0]   hdr_len_q;

   // admission test for a frame starting this cycle
   int   req_len;
   int   need_bytes;
   logic fits;
   logic start;
   logic accept;

   always_comb begin
      req_len    = (int'(in_len) < MIN_LEN) ? MIN_LEN : int'(in_len);
      need_bytes = record_bytes(req_len);
      fits       = int'(free_bytes) >= need_bytes;
      start      = (state_q == W_IDLE) && in_valid && in_first;
      accept     = start && rx_en && fits;
   end

   // CRC datapath: one byte per cycle
   logic [31:0] crc_src;
   logic [7:0]  crc_byte;
   logic [31:0] crc_nxt;
   logic [31:0] crc_fin;

   assign crc_src  = (state_q == W_IDLE) ? 32'hFFFF_FFFF : crc_q;
   assign crc_byte = (state_q == W_PAD) ? 8'h00 : in_data;
   assign crc_fin  = ~crc_q;

   rxq_crc_step #(.BITS(8), .POLY(CRC_POLY_REFL)) u_crc (
      .crc_in  (crc_src),
      .data_in (crc_byte),
      .crc_out (crc_nxt)
   );

   logic [31:0] hdr_word;
   assign hdr_word = {OK_CODE, hdr_len_q};

   // memory write port
   always_comb begin
      wr_en   = 1'b0;
      wr_addr = base_q + off_q[AW-1:0];
      wr_byte = 8'h00;
      unique case (state_q)
         W_IDLE: begin
            wr_en   = accept;
            wr_addr = base_q + AW'(HDR_BYTES);
            wr_byte = in_data;
         end
         W_DATA: begin
            wr_en   = in_valid;
            wr_byte = in_data;
         end
         W_PAD, W_ALIGN: begin
            wr_en = 1'b1;
         end
         W_CRC: begin
            wr_en   = 1'b1;
            wr_byte = crc_fin[8*sub_q[1:0] +: 8];
         end
         W_HEAD: begin
            wr_en   = 1'b1;
            wr_addr = base_q + AW'(sub_q);
            wr_byte = sub_q[2] ? hdr_word[8*sub_q[1:0] +: 8]
                               : MARKER[8*sub_q[1:0] +: 8];
         end
         default: ;
      endcase
   end

   assign commit       = (state_q == W_HEAD) && (sub_q == 3'd7);
   assign commit_bytes = off_q[AW:0];
   assign idle         = (state_q == W_IDLE);

   // after the last payload byte: zero fill or straight to the CRC
   function automatic wr_state_t after_payload(input logic [LW-1:0] nxt_off);
      return (nxt_off < OFF_PAD_END) ? W_PAD : W_CRC;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= W_IDLE;
         base_q    <= '0;
         off_q     <= '0;
         crc_q     <= '1;
         sub_q     <= '0;
         hdr_len_q <= '0;
      end else begin
         unique case (state_q)
            W_IDLE: begin
               if (accept) begin
                  off_q     <= OFF_FIRST + LW'(1);
                  crc_q     <= crc_nxt;
                  sub_q     <= '0;
                  hdr_len_q <= 16'(OFF_FIRST + LW'(1) - OFF_FIRST + LW'(CRC_BYTES));
                  state_q   <= in_last ? after_payload(OFF_FIRST + LW'(1)) : W_DATA;
               end else if (start && !in_last) begin
                  state_q <= W_SKIP;
               end
            end
            W_DATA: begin
               if (in_valid) begin
                  off_q     <= off_q + LW'(1);
                  crc_q     <= crc_nxt;
                  hdr_len_q <= 16'(off_q + LW'(1) - OFF_FIRST + LW'(CRC_BYTES));
                  if (in_last) state_q <= after_payload(off_q + LW'(1));
               end
            end
            W_PAD: begin
               off_q <= off_q + LW'(1);
               crc_q <= crc_nxt;
               if (off_q + LW'(1) == OFF_PAD_END) begin
                  hdr_len_q <= 16'(MIN_LEN + CRC_BYTES);
                  state_q   <= W_CRC;
               end
            end
            W_CRC: begin
               off_q <= off_q + LW'(1);
               sub_q <= sub_q + 3'd1;
               if (sub_q[1:0] == 2'd3) begin
                  sub_q   <= '0;
                  state_q <= ((off_q[1:0] + 2'd1) == 2'd0) ? W_HEAD : W_ALIGN;
               end
            end
            W_ALIGN: begin
               off_q <= off_q + LW'(1);
               if ((off_q[1:0] + 2'd1) == 2'd0) state_q <= W_HEAD;
            end
            W_HEAD: begin
               sub_q <= sub_q + 3'd1;
               if (sub_q == 3'd7) begin
                  base_q  <= base_q + off_q[AW-1:0];
                  sub_q   <= '0;
                  state_q <= W_IDLE;
               end
            end
            W_SKIP: begin
               if (in_valid && in_last) state_q <= W_IDLE;
            end
            default: state_q <= W_IDLE;
         endcase
      end
   end

   // R2: every committed record is word aligned and at least minimum size
   p_commit_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (commit_bytes[1:0] == 2'b00) &&
                 (int'(commit_bytes) >= record_bytes(MIN_LEN)));

   // R5: a discarded frame leaves the memory untouched
   p_skip_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_SKIP) |-> !wr_en);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 4096,
   parameter int AW    = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_byte,
   input  logic          commit,
   input  logic [AW:0]   commit_bytes,
   input  logic          pop,
   output logic [31:0]   rd_word,
   output logic [AW:0]   free_bytes
);

   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] head_q;
   logic [AW:0]   used_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_byte;
   end

   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [AW-1:0] lane_addr;
      assign lane_addr          = head_q + AW'(g);
      assign rd_word[8*g +: 8]  = mem[lane_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         used_q <= '0;
      end else begin
         if (pop) head_q <= head_q + AW'(4);
         used_q <= used_q + (commit ? commit_bytes : '0) - (pop ? (AW+1)'(4) : '0);
      end
   end

   assign free_bytes = FULL - used_q;

   // R12: occupancy bounded and pops backed by stored data
   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= FULL);

   p_pop_has_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (used_q >= (AW+1)'(4)));

endmodule

// File: rtl/rxq_reader.sv
module rxq_reader
   import rxq_pkg::*;
#(
   parameter int PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stb,
   input  logic [15:0]   hdr_len,
   input  logic          commit,
   output logic          pop,
   output logic          rd_err,
   output logic [PW-1:0] pend_cnt
);

   rd_pos_t     pos_q;
   logic [15:0] rem_q;
   logic        done;

   assign pop  = rd_stb && (pend_cnt != '0);
   assign done = pop && (pos_q == P_BODY) && (rem_q == 16'd4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q    <= P_MARK;
         rem_q    <= '0;
         rd_err   <= 1'b0;
         pend_cnt <= '0;
      end else begin
         rd_err   <= rd_stb && (pend_cnt == '0);
         pend_cnt <= pend_cnt + (commit ? PW'(1) : '0) - (done ? PW'(1) : '0);
         if (pop) begin
            unique case (pos_q)
               P_MARK: pos_q <= P_HDR;
               P_HDR: begin
                  rem_q <= (hdr_len + 16'd3) & ~16'd3;
                  pos_q <= P_BODY;
               end
               P_BODY: begin
                  rem_q <= rem_q - 16'd4;
                  if (rem_q == 16'd4) pos_q <= P_MARK;
               end
               default: pos_q <= P_MARK;
            endcase
         end
      end
   end

   // R9: the pending count only falls when a record body ends
   p_pend_drop_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_cnt < $past(pend_cnt)) |-> ($past(pos_q) == P_BODY));

   // R10: an empty read produces an error pulse
   p_empty_read_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && pend_cnt == '0) |=> rd_err && $stable(pos_q));

endmodule

// File: rtl/rx_record_fifo.sv
module rx_record_fifo
   import rxq_pkg::*;
#(
   parameter int          DEPTH   = 4096,
   parameter int          LEN_W   = 16,
   parameter int          MIN_LEN = 60,
   parameter int          RDY_MIN = 1532,
   parameter logic [31:0] MARKER  = 32'hA5C3_0F1E,
   parameter logic [15:0] OK_CODE = 16'h0001
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_en,
   input  logic                     in_valid,
   input  logic                     in_first,
   input  logic                     in_last,
   input  logic [7:0]               in_data,
   input  logic [LEN_W-1:0]         in_len,
   output logic                     rdy,
   input  logic                     rd_stb,
   output logic [31:0]              rd_word,
   output logic                     rd_err,
   output logic [$clog2(DEPTH)-1:0] pend_cnt,
   output logic                     irq,
   input  logic                     irq_clr
);

   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH || DEPTH < 128) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 128");
   end
   if (RDY_MIN > DEPTH) begin : g_bad_rdy
      $error("RDY_MIN must not exceed DEPTH");
   end
   if (LEN_W <= AW) begin : g_bad_lenw
      $error("LEN_W must exceed the address width");
   end
   if (MIN_LEN < 1) begin : g_bad_min
      $error("MIN_LEN must be at least 1");
   end

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_byte;
   logic          commit;
   logic [AW:0]   commit_bytes;
   logic          wr_idle;
   logic [AW:0]   free_bytes;
   logic          pop;

   rxq_writer #(
      .AW(AW), .LW(LEN_W), .MIN_LEN(MIN_LEN), .MARKER(MARKER), .OK_CODE(OK_CODE)
   ) u_wr (
      .clk, .rst_n, .rx_en, .in_valid, .in_first, .in_last, .in_data, .in_len,
      .free_bytes, .wr_en, .wr_addr, .wr_byte, .commit, .commit_bytes,
      .idle (wr_idle)
   );

   rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_byte, .commit, .commit_bytes,
      .pop, .rd_word, .free_bytes
   );

   rxq_reader #(.PW(AW)) u_rd (
      .clk, .rst_n, .rd_stb,
      .hdr_len (rd_word[15:0]),
      .commit, .pop, .rd_err, .pend_cnt
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       irq <= 1'b0;
      else if (commit)  irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
   end

   assign rdy = rx_en && wr_idle && (int'(free_bytes) >= RDY_MIN);

   // R7: the interrupt only rises after a record is committed
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(commit));

   // R6: ready is never shown while a record is being written
   p_rdy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> wr_idle);

endmodule

// File: tb/sim_rx_record_fifo.sv
module sim_rx_record_fifo;

   localparam int          DEPTH   = 256;
   localparam int          LEN_W   = 16;
   localparam int          MIN_LEN = 60;
   localparam int          RDY_MIN = 100;
   localparam logic [31:0] MARKER  = 32'h1234_ABCD;
   localparam logic [15:0] OK_CODE = 16'h0080;
   localparam int          PW      = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_en = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_first = 1'b0;
   logic             in_last = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic [LEN_W-1:0] in_len = '0;
   logic             rdy;
   logic             rd_stb = 1'b0;
   logic [31:0]      rd_word;
   logic             rd_err;
   logic [PW-1:0]    pend_cnt;
   logic             irq;
   logic             irq_clr = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rx_record_fifo #(
      .DEPTH(DEPTH), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .RDY_MIN(RDY_MIN),
      .MARKER(MARKER), .OK_CODE(OK_CODE)
   ) u0 (
      .clk, .rst_n, .rx_en, .in_valid, .in_first, .in_last, .in_data, .in_len,
      .rdy, .rd_stb, .rd_word, .rd_err, .pend_cnt, .irq, .irq_clr
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 31 + i * 7 + 3) & 255);
   endfunction

   function automatic int stored_len(input int len);
      return (len < MIN_LEN) ? MIN_LEN : len;
   endfunction

   function automatic logic [31:0] exp_crc(input int len, input int seed);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < stored_len(len); i++) begin
         logic [7:0] b = (i < len) ? pat(seed, i) : 8'h00;
         c = c ^ {24'h0, b};
         for (int k = 0; k < 8; k++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic send(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_first = (i == 0);
         in_last  = (i == len - 1);
         in_data  = pat(seed, i);
         in_len   = LEN_W'(len);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic settle();
      repeat (90) @(negedge clk);
   endtask

   task automatic pop_word();
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   // reads one record and checks every word (R1 R2 R3 R4 R8 R9)
   task automatic read_record(input int len, input int seed);
      int          plen = stored_len(len);
      logic [31:0] crc  = exp_crc(len, seed);
      int          body = (plen + 4 + 3) & ~3;
      int          pend0 = int'(pend_cnt);
      logic [31:0] w;
      chk(rd_word == MARKER, "R2 marker", rd_word, MARKER);
      pop_word();
      w = {OK_CODE, 16'(plen + 4)};
      chk(rd_word == w, "R3 header", rd_word, w);
      pop_word();
      for (int k = 0; k < body / 4; k++) begin
         for (int b = 0; b < 4; b++) begin
            int j = k * 4 + b;
            logic [7:0] eb;
            if (j < len)           eb = pat(seed, j);
            else if (j < plen)     eb = 8'h00;
            else if (j < plen + 4) eb = crc[8*(j-plen) +: 8];
            else                   eb = 8'h00;
            w[8*b +: 8] = eb;
         end
         chk(rd_word == w, "R1 R4 R8 body word", rd_word, w);
         pop_word();
      end
      chk(int'(pend_cnt) == pend0 - 1, "R9 pend after record", 32'(pend_cnt),
          32'(pend0 - 1));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pend_cnt == '0, "R7 reset pend", 32'(pend_cnt), 0);
      chk(irq == 1'b0, "R7 reset irq", 32'(irq), 0);
      chk(rdy == 1'b0, "R6 rdy with rx_en low", 32'(rdy), 0);
      chk(rd_err == 1'b0, "R10 reset err", 32'(rd_err), 0);
      rx_en = 1'b1;
      @(negedge clk);
      chk(rdy == 1'b1, "R6 rdy enabled empty", 32'(rdy), 1);

      // sweep of payload lengths
      for (int len = 1; len <= 72; len++) begin
         send(len, len);
         chk(rdy == 1'b0, "R6 rdy low while writing", 32'(rdy), 0);
         settle();
         chk(pend_cnt == PW'(1), "R7 pend after frame", 32'(pend_cnt), 1);
         chk(irq == 1'b1, "R7 irq set", 32'(irq), 1);
         read_record(len, len);
         irq_clr = 1'b1;
         @(negedge clk);
         irq_clr = 1'b0;
         chk(irq == 1'b0, "R7 irq cleared", 32'(irq), 0);
      end

      // space limit: two large frames, then a rejected small one
      send(100, 7);
      settle();
      chk(rdy == 1'b1, "R6 rdy free 144", 32'(rdy), 1);
      send(100, 8);
      settle();
      chk(pend_cnt == PW'(2), "R7 two pending", 32'(pend_cnt), 2);
      chk(rdy == 1'b0, "R6 rdy free 32", 32'(rdy), 0);
      send(10, 9);
      settle();
      chk(pend_cnt == PW'(2), "R5 no space drop", 32'(pend_cnt), 2);
      read_record(100, 7);
      read_record(100, 8);
      chk(pend_cnt == '0, "R9 drained", 32'(pend_cnt), 0);

      // receive disabled
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      rx_en = 1'b0;
      send(20, 11);
      settle();
      chk(pend_cnt == '0, "R5 disabled drop", 32'(pend_cnt), 0);
      chk(irq == 1'b0, "R5 disabled no irq", 32'(irq), 0);
      rx_en = 1'b1;
      send(30, 12);
      settle();
      read_record(30, 12);

      // frame starting during the tail of the previous record
      send(10, 13);
      send(12, 14);
      settle();
      chk(pend_cnt == PW'(1), "R11 busy start dropped", 32'(pend_cnt), 1);
      read_record(10, 13);

      // empty read
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk(rd_err == 1'b1, "R10 err pulse", 32'(rd_err), 1);
      @(negedge clk);
      chk(rd_err == 1'b0, "R10 err single cycle", 32'(rd_err), 0);
      chk(pend_cnt == '0, "R10 pend unchanged", 32'(pend_cnt), 0);
      send(64, 15);
      settle();
      read_record(64, 15);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule